// File: doc/BRIEF.md
# Byte-Serial AES-128 Cipher Core

This block encrypts or decrypts one 128-bit block under a 128-bit key. A single 8-bit substitution unit does all of the work. The 16-byte state is visited one byte per cycle. The row rotation of each round comes from the order in which the controller fetches state bytes, so no bytes are moved to rotate a row. The column mix is built up serially: each substituted byte is scaled by its fixed coefficient and XOR-added into four running column sums. Round keys are derived during the rounds and are never stored as a table. The same substitution unit also serves the key schedule, which takes four cycles at the head of every round.

To use the block, present the key, the data and the direction, then pulse `start` for one cycle while the core is idle. An encryption begins its rounds at once. A decryption first runs the key schedule forward ten times to reach the last round key, then walks the schedule backwards during its rounds. When the block is finished, `done` pulses for one cycle and `result` holds the output block until the next accepted start.

Top module: `aes_byte_core`

## Requirements
- R1: With key 000102030405060708090a0b0c0d0e0f and plaintext 00112233445566778899aabbccddeeff, encryption (`decrypt`=0) gives 69c4e0d86a7b0430d8cdb78070b4c55a. With key 2b7e151628aed2a6abf7158809cf4f3c and plaintext 3243f6a8885a308d313198a2e0370734, it gives 3925841d02dc09fbdc118597196a0b32. Byte 0 of every 128-bit port is bits [127:120], and byte k sits in row k mod 4, column k div 4.
- R2: Decryption (`decrypt`=1) of either ciphertext in R1 under its key returns the matching plaintext.
- R3: For any key and block, decrypting the encryption result under the same key returns the original block.
- R4: An encryption raises `done` exactly 200 rising edges after the edge that samples `start`.
- R5: A decryption raises `done` exactly 240 rising edges after the edge that samples `start`.
- R6: `done` is high for exactly one cycle per operation.
- R7: While the core is idle and `start` is low, `result` does not change, whatever `key_in`, `data_in` and `decrypt` do.
- R8: A `start` pulse during an operation is ignored: the result and the latency of that operation do not change.
- R9: `decrypt` is sampled only together with an accepted `start`. Toggling it during an operation has no effect on that operation.
- R10: In forward mode the substitution unit maps 00 to 63 and 53 to ed. Over all 256 inputs, the inverse mode undoes the forward mode.
- R11: After reset, `done` is 0 and `result` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins an operation when the core is idle |
| decrypt | input | 1 | 1 selects decryption, 0 selects encryption; sampled with start |
| key_in | input | 128 | Cipher key, byte 0 in bits [127:120] |
| data_in | input | 128 | Input block, byte 0 in bits [127:120] |
| done | output | 1 | One-cycle pulse when the result is ready |
| result | output | 128 | Output block, held until the next accepted start |

## Verification
Each operation has a fixed cost. The schedule costs four cycles per round, and the data pass costs sixteen cycles per round. Over ten rounds that gives 200 edges for an encryption, and 40 more for a decryption, which first runs the forward key expansion. The bench drives inputs on falling edges and counts falling edges after the edge that samples `start`, so `done` must show up at count 200 or 240 exactly. Any other count is reported against R4 or R5. The one-cycle width of `done` is checked one falling edge later. The hold of `result` and the ignored mid-run start and mode changes are each checked at the first falling edge after the state they could have disturbed has settled.

// File: rtl/aes_pkg.sv
package aes_pkg;
    localparam int BYTE_W = 8;
    localparam int NB     = 16;
    localparam int BLK_W  = NB * BYTE_W;
    localparam int ROWS   = 4;
    localparam int COL_W  = ROWS * BYTE_W;
    localparam int ROUNDS = 10;
    localparam int RND_W  = $clog2(ROUNDS + 1);
    localparam int CNT_W  = $clog2(NB);

    typedef enum logic [1:0] {PH_IDLE, PH_PRE, PH_KEY, PH_DATA} phase_e;

    typedef struct packed {
        phase_e             ph;
        logic               dec;
        logic [RND_W-1:0]   rnd;
        logic [CNT_W-1:0]   cnt;
        logic [BLK_W-1:0]   st;
        logic [BLK_W-1:0]   ns;
        logic [BLK_W-1:0]   rk;
        logic [BYTE_W-1:0]  rcon;
        logic [COL_W-9:0]   tmp;
        logic [COL_W-1:0]   acc;
        logic               done;
    } regs_t;

    function automatic logic [7:0] xtime(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    // multiply by x^-1 modulo the field polynomial
    function automatic logic [7:0] xdiv(input logic [7:0] a);
        return a[0] ? (((a ^ 8'h1b) >> 1) | 8'h80) : (a >> 1);
    endfunction

    function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = 8'h00;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p ^= x;
            x = xtime(x);
        end
        return p;
    endfunction

    // inverse through the GF(2^4) subfield: a^17 is the norm, its inverse is norm^14
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] a2, a4, a8, a16, n, n2, n4, n8;
        a2  = gmul(a, a);
        a4  = gmul(a2, a2);
        a8  = gmul(a4, a4);
        a16 = gmul(a8, a8);
        n   = gmul(a16, a);
        n2  = gmul(n, n);
        n4  = gmul(n2, n2);
        n8  = gmul(n4, n4);
        return gmul(a16, gmul(gmul(n2, n4), n8));
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] x, input int n);
        return (x << n) | (x >> (8 - n));
    endfunction

    function automatic logic [7:0] aff_fwd(input logic [7:0] b);
        return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
    endfunction

    function automatic logic [7:0] aff_inv(input logic [7:0] y);
        return rotl8(y, 1) ^ rotl8(y, 3) ^ rotl8(y, 6) ^ 8'h05;
    endfunction

    function automatic logic [7:0] get_byte(input logic [BLK_W-1:0] v, input logic [3:0] b);
        return v[BLK_W-1-8*int'(b) -: 8];
    endfunction

    // mixing coefficient for output row i and input row j
    function automatic logic [7:0] coef(input logic dec, input logic last,
                                       input int i, input logic [1:0] j);
        logic [1:0] d = 2'(int'(j) - i);
        logic [7:0] fw [4] = '{8'h02, 8'h03, 8'h01, 8'h01};
        logic [7:0] iv [4] = '{8'h0e, 8'h0b, 8'h0d, 8'h09};
        if (last) return (d == 2'd0) ? 8'h01 : 8'h00;
        return dec ? iv[d] : fw[d];
    endfunction
endpackage

// File: rtl/aes_sbox.sv
module aes_sbox
    import aes_pkg::*;
(
    input  logic [BYTE_W-1:0] sb_in,
    input  logic              sb_inv,
    output logic [BYTE_W-1:0] sb_out
);
    logic [BYTE_W-1:0] pre_q;
    logic [BYTE_W-1:0] inv_v;

    always_comb begin
        pre_q  = sb_inv ? aff_inv(sb_in) : sb_in;
        inv_v  = gf_inv(pre_q);
        sb_out = sb_inv ? inv_v : aff_fwd(inv_v);
    end
endmodule

// File: rtl/aes_keystep.sv
module aes_keystep
    import aes_pkg::*;
(
    input  logic [BLK_W-1:0]  ks_key,
    input  logic [COL_W-1:0]  ks_sub,
    input  logic [BYTE_W-1:0] ks_rc,
    input  logic              ks_rev,
    output logic [BLK_W-1:0]  ks_next
);
    logic [COL_W-1:0] w [ROWS];
    logic [COL_W-1:0] n [ROWS];
    logic [COL_W-1:0] rcw;

    for (genvar c = 0; c < ROWS; c++) begin : g_col
        assign w[c] = ks_key[BLK_W-1-COL_W*c -: COL_W];
        assign ks_next[BLK_W-1-COL_W*c -: COL_W] = n[c];
    end

    always_comb begin
        rcw = {ks_rc, {(COL_W-BYTE_W){1'b0}}};
        if (ks_rev) begin
            n[3] = w[3] ^ w[2];
            n[2] = w[2] ^ w[1];
            n[1] = w[1] ^ w[0];
            n[0] = w[0] ^ ks_sub ^ rcw;
        end else begin
            n[0] = w[0] ^ ks_sub ^ rcw;
            n[1] = w[1] ^ n[0];
            n[2] = w[2] ^ n[1];
            n[3] = w[3] ^ n[2];
        end
    end
endmodule

// File: rtl/aes_byte_core.sv
module aes_byte_core
    import aes_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             decrypt,
    input  logic [BLK_W-1:0] key_in,
    input  logic [BLK_W-1:0] data_in,
    output logic             done,
    output logic [BLK_W-1:0] result
);
    regs_t q, d;

    logic [BYTE_W-1:0] sb_in, sb_out, kin, din;
    logic              sb_inv, ks_rev;
    logic [BYTE_W-1:0] ks_rc;
    logic [COL_W-1:0]  ks_sub;
    logic [BLK_W-1:0]  ks_out;
    logic [1:0]        row, colo, fcol, kb;

    aes_sbox u_sbox (.sb_in(sb_in), .sb_inv(sb_inv), .sb_out(sb_out));

    aes_keystep u_ks (.ks_key(q.rk), .ks_sub(ks_sub), .ks_rc(ks_rc),
                      .ks_rev(ks_rev), .ks_next(ks_out));

    assign ks_sub = {q.tmp, sb_out};

    // operand selection for the shared substitution unit
    always_comb begin
        row  = q.cnt[1:0];
        colo = q.cnt[3:2];
        kb   = 2'(row + 2'd1);
        fcol = q.dec ? 2'(colo - row) : 2'(colo + row);
        din  = get_byte(q.st, {fcol, row});
        kin  = get_byte(q.rk, {2'd3, kb});
        ks_rev = (q.ph == PH_KEY) && q.dec;
        if (ks_rev) kin = kin ^ get_byte(q.rk, {2'd2, kb});
        ks_rc  = ks_rev ? xdiv(q.rcon) : q.rcon;
        sb_in  = (q.ph == PH_DATA) ? din : kin;
        sb_inv = (q.ph == PH_DATA) && q.dec;
    end

    always_comb begin
        logic [BYTE_W-1:0] v, a;
        logic [COL_W-1:0]  nacc;
        logic              last;
        d      = q;
        d.done = 1'b0;
        last   = (q.rnd == RND_W'(ROUNDS));
        v      = q.dec ? (sb_out ^ get_byte(q.rk, {colo, row})) : sb_out;
        nacc   = '0;
        for (int i = 0; i < ROWS; i++) begin
            a = (row == 2'd0) ? 8'h00 : q.acc[COL_W-1-8*i -: 8];
            nacc[COL_W-1-8*i -: 8] = a ^ gmul(coef(q.dec, last, i, row), v);
        end
        case (q.ph)
            PH_IDLE: if (start) begin
                d.dec  = decrypt;
                d.rk   = key_in;
                d.rcon = 8'h01;
                d.cnt  = '0;
                if (decrypt) begin
                    d.st  = data_in;
                    d.rnd = '0;
                    d.ph  = PH_PRE;
                end else begin
                    d.st  = data_in ^ key_in;
                    d.rnd = RND_W'(1);
                    d.ph  = PH_KEY;
                end
            end
            PH_PRE, PH_KEY: begin
                d.cnt = q.cnt + CNT_W'(1);
                if (row != 2'd3) begin
                    d.tmp[COL_W-9-8*int'(row) -: 8] = sb_out;
                end else begin
                    d.cnt = '0;
                    d.rk  = ks_out;
                    if (q.ph == PH_PRE) begin
                        d.rcon = xtime(q.rcon);
                        d.rnd  = q.rnd + RND_W'(1);
                        if (q.rnd == RND_W'(ROUNDS - 1)) begin
                            d.st  = q.st ^ ks_out;
                            d.rnd = RND_W'(1);
                            d.ph  = PH_KEY;
                        end
                    end else begin
                        d.rcon = ks_rev ? ks_rc : xtime(q.rcon);
                        d.ph   = PH_DATA;
                    end
                end
            end
            PH_DATA: begin
                d.acc = nacc;
                d.cnt = q.cnt + CNT_W'(1);
                if (row == 2'd3) begin
                    for (int i = 0; i < ROWS; i++) begin
                        d.ns[BLK_W-1-8*(4*int'(colo)+i) -: 8] = nacc[COL_W-1-8*i -: 8] ^
                            (q.dec ? 8'h00 : get_byte(q.rk, {colo, 2'(i)}));
                    end
                end
                if (q.cnt == CNT_W'(NB - 1)) begin
                    d.st = d.ns;
                    if (last) begin
                        d.ph   = PH_IDLE;
                        d.done = 1'b1;
                    end else begin
                        d.rnd = q.rnd + RND_W'(1);
                        d.ph  = PH_KEY;
                    end
                end
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= regs_t'('0);
        else        q <= d;
    end

    assign done   = q.done;
    assign result = q.st;

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);
    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_IDLE && !start) |=> $stable(result));
    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph != PH_IDLE) |=> $stable(q.dec));
    // R4
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.done) |-> ($past(q.ph) == PH_DATA && $past(q.rnd) == RND_W'(ROUNDS)));
    // R8
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_KEY && start) |=> (q.ph != PH_PRE));
    // R5
    key_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_KEY || q.ph == PH_PRE) |-> (q.cnt < CNT_W'(4)));
endmodule

// File: tb/aes_byte_core_bench.sv
`timescale 1ns/1ps
module aes_byte_core_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         decrypt = 1'b0;
    logic [127:0] key_in = '0;
    logic [127:0] data_in = '0;
    logic         done;
    logic [127:0] result;
    logic [7:0]   tin = '0;
    logic         tinv = 1'b0;
    logic [7:0]   tout;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    aes_byte_core u_aes_byte_core (.clk(clk), .rst_n(rst_n), .start(start),
        .decrypt(decrypt), .key_in(key_in), .data_in(data_in),
        .done(done), .result(result));

    aes_sbox u_sbox_probe (.sb_in(tin), .sb_inv(tinv), .sb_out(tout));

    task automatic chk(input logic ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // runs one operation; noisy adds a mid-run start and mode flips
    task automatic run_op(input logic [127:0] k, input logic [127:0] x,
                          input logic dec, input logic noisy,
                          output logic [127:0] res, output int lat);
        int n = 0;
        @(negedge clk);
        key_in = k; data_in = x; decrypt = dec; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = -1;
        while (n < 1000) begin
            @(negedge clk);
            n++;
            if (noisy && n == 50) begin
                start = 1'b1; decrypt = ~dec;
                data_in = {$urandom, $urandom, $urandom, $urandom};
            end
            if (noisy && n == 51) start = 1'b0;
            if (noisy && n == 100) key_in = ~k;
            if (noisy && n == 120) decrypt = dec;
            if (done) begin lat = n; break; end
        end
        res = result;
        @(negedge clk);
        chk(!done, "R6 done width", {127'd0, done}, 128'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [127:0] r, h, k, p;
        int lat;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(done == 1'b0, "R11 done", {127'd0, done}, 128'd0);
        chk(result == '0, "R11 result", result, 128'd0);
        rst_n = 1'b1;

        // R10 substitution sweep
        tinv = 1'b0; tin = 8'h00; #1;
        chk(tout == 8'h63, "R10 S(00)", {120'd0, tout}, 128'h63);
        tin = 8'h53; #1;
        chk(tout == 8'hed, "R10 S(53)", {120'd0, tout}, 128'hed);
        for (int x = 0; x < 256; x++) begin
            logic [7:0] y;
            tinv = 1'b0; tin = 8'(x); #1;
            y = tout;
            tinv = 1'b1; tin = y; #1;
            chk(tout == 8'(x), "R10 inverse", {120'd0, tout}, 128'(x));
        end

        // R1, R4 known encryptions
        run_op(128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff,
               1'b0, 1'b0, r, lat);
        chk(r == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R1 vector A", r,
            128'h69c4e0d86a7b0430d8cdb78070b4c55a);
        chk(lat == 200, "R4 latency", 128'(lat), 128'd200);
        run_op(128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h3243f6a8885a308d313198a2e0370734,
               1'b0, 1'b0, r, lat);
        chk(r == 128'h3925841d02dc09fbdc118597196a0b32, "R1 vector B", r,
            128'h3925841d02dc09fbdc118597196a0b32);

        // R7 hold while idle with moving inputs
        h = result;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            key_in = {$urandom, $urandom, $urandom, $urandom};
            data_in = {$urandom, $urandom, $urandom, $urandom};
            decrypt = ~decrypt;
        end
        @(negedge clk);
        chk(result == h, "R7 hold", result, h);

        // R2, R5 known decryptions
        run_op(128'h000102030405060708090a0b0c0d0e0f, 128'h69c4e0d86a7b0430d8cdb78070b4c55a,
               1'b1, 1'b0, r, lat);
        chk(r == 128'h00112233445566778899aabbccddeeff, "R2 vector A", r,
            128'h00112233445566778899aabbccddeeff);
        chk(lat == 240, "R5 latency", 128'(lat), 128'd240);
        run_op(128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h3925841d02dc09fbdc118597196a0b32,
               1'b1, 1'b0, r, lat);
        chk(r == 128'h3243f6a8885a308d313198a2e0370734, "R2 vector B", r,
            128'h3243f6a8885a308d313198a2e0370734);

        // R8, R9 mid-run start and mode changes ignored
        run_op(128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff,
               1'b0, 1'b1, r, lat);
        chk(r == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R8 R9 noisy encrypt", r,
            128'h69c4e0d86a7b0430d8cdb78070b4c55a);
        chk(lat == 200, "R8 noisy latency", 128'(lat), 128'd200);
        run_op(128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h3925841d02dc09fbdc118597196a0b32,
               1'b1, 1'b1, r, lat);
        chk(r == 128'h3243f6a8885a308d313198a2e0370734, "R8 R9 noisy decrypt", r,
            128'h3243f6a8885a308d313198a2e0370734);
        chk(lat == 240, "R8 noisy dec latency", 128'(lat), 128'd240);

        // R3 round trips
        for (int t = 0; t < 12; t++) begin
            k = {$urandom, $urandom, $urandom, $urandom};
            p = {$urandom, $urandom, $urandom, $urandom};
            if (t == 0) k = '0;
            if (t == 1) p = '1;
            run_op(k, p, 1'b0, 1'b0, r, lat);
            chk(r != p, "R3 ciphertext differs", r, p);
            run_op(k, r, 1'b1, 1'b0, h, lat);
            chk(h == p, "R3 round trip", h, p);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule